// File: doc/BRIEF.md
# Stereo I2S Transmit Port with Rate Select and GPIO Fallback

This block sends stereo PCM sample pairs to an external DAC over I2S. A left/right pair arrives in parallel through a valid/ready handshake. The block turns each pair into a serial frame on four pins: a master clock, a bit clock, a word-select line and a serial data line. All of it runs from the single system clock `clk`. The master clock pin has a half-period of one `clk` cycle. When the clock-range strap `clk_range_hi` is high, the half-period is two `clk` cycles, which suits a system clock in the doubled frequency band.

A 4-bit configuration register sets the behaviour. It selects the bit-clock divider, gates the master clock pin and switches the port on or off. While the port is off, the four pins carry the GPIO value and GPIO output enable supplied by the surrounding chip. Any change that affects timing (the enable bit, the rate code or the range strap) restarts the dividers and the frame. The new frame therefore always begins cleanly on the left channel.

Top module: `i2s_tx_port`

## Requirements
- R1: The configuration register `cfg_rdata` resets to 0 and takes `cfg_wdata` on each cycle with `cfg_we` high. Bit 3 gates the master clock, bit 2 enables the port, and bits 1:0 hold the rate code.
- R2: In bit-clock half-periods, counted in master clock half-periods, rate code 00 gives 8, 01 gives 4 and 10 gives 2. The reserved code 11 behaves like 00. A full bit-clock period is therefore 16, 8 or 4 `clk` cycles when `clk_range_hi` is 0, and twice that when it is 1.
- R3: `pin_out[0]` is the master clock. Its half-period is 1 `clk` cycle, or 2 when `clk_range_hi` is 1. It is held low when bit 3 is clear and the port is enabled, and the bit clock keeps running.
- R4: When bit 2 is clear, `pin_out` and `pin_oe` are one-cycle-registered copies of `gpio_out` and `gpio_oe`. This mode is the state after reset.
- R5: When bit 2 is set, all four bits of `pin_oe` are 1.
- R6: `pin_out[1]` is the bit clock and `pin_out[2]` is the word select. Each frame has 32 slots of one bit-clock period. Each slot starts at a bit-clock falling edge. The word select is low for slots 0 to 15 (left) and high for slots 16 to 31 (right).
- R7: `pin_out[3]` carries the data MSB first, one slot after the word select changes. Slot 1 carries left bit 15, slot 16 left bit 0, slot 17 right bit 15, and slot 0 of the next frame right bit 0.
- R8: `s_ready` is high for exactly one cycle per frame, in the cycle of the falling edge that ends slot 31. A pair offered with `s_valid` in that cycle is used for the next frame. Without it, the previous pair is sent again.
- R9: A write that changes bit 2 or bits 1:0, or a change of `clk_range_hi`, restarts the port. Both clocks go low, the word select goes low and the next frame starts at slot 0. A write that changes only bit 3 does not disturb the timing.
- R10: A pair accepted in the same cycle as a restart is the pair sent in the first frame after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_range_hi | input | 1 | Clock-range strap; 1 halves the master clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write value |
| cfg_rdata | output | 4 | Current configuration |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Pair taken in this cycle |
| s_left | input | WORD | Left sample |
| s_right | input | WORD | Right sample |
| gpio_out | input | 4 | Pin values used in GPIO mode |
| gpio_oe | input | 4 | Pin enables used in GPIO mode |
| pin_out | output | 4 | Pin values: 0 master clock, 1 bit clock, 2 word select, 3 data |
| pin_oe | output | 4 | Pin output enables |

## Verification
The hard coincidence is a sample pair accepted in the same cycle as a configuration write that restarts the frame. The bench waits at a falling clock edge until `s_ready` is high, then drives a rate-changing write in that same cycle. It then rebuilds the first left word from the data pin on bit-clock rising edges and compares it with the pair that was on offer. Every cycle, the pins are also compared with a behavioural frame model, which treats the handshake and the restart as two independent events that share an edge.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int CFG_W  = 4;
  localparam int CNT_W  = 5;
  localparam int NPIN   = 4;
  localparam int PIN_MC = 0;
  localparam int PIN_BC = 1;
  localparam int PIN_WS = 2;
  localparam int PIN_SD = 3;

  typedef enum logic [1:0] {
    RATE_BASE   = 2'b00,
    RATE_DOUBLE = 2'b01,
    RATE_QUAD   = 2'b10,
    RATE_RSVD   = 2'b11
  } rate_e;

  typedef struct packed {
    logic  mclk_on;
    logic  port_on;
    rate_e rate;
  } cfg_t;

  // bit-clock half-period in system clock cycles
  function automatic logic [CNT_W-1:0] half_period(input rate_e r, input logic hi_range);
    logic [CNT_W-1:0] base;
    case (r)
      RATE_DOUBLE: base = CNT_W'(4);
      RATE_QUAD:   base = CNT_W'(2);
      default:     base = CNT_W'(8);
    endcase
    return hi_range ? (base << 1) : base;
  endfunction

endpackage

// File: rtl/i2s_tx_cfg.sv
module i2s_tx_cfg
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             range_hi,
  output cfg_t             cfg_q,
  output logic             range_q,
  output logic             restart
);

  logic timing_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      range_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_t'(wr_data);
      range_q <= range_hi;
    end
  end

  assign timing_write = wr_en && (wr_data[2:0] != {cfg_q.port_on, cfg_q.rate});
  assign restart      = timing_write || (range_hi != range_q) || !cfg_q.port_on;

  // R1: without a write the register keeps its value
  a_r1_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q));

  // R9: a timing-relevant write always leads to a restart request
  a_r9_write_restarts: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[2] != cfg_q.port_on) |-> restart);

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] half_len,
  input  logic          range_q,
  output logic          mclk,
  output logic          sclk,
  output logic          fall
);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == half_len - CW'(1));
  assign fall   = at_end && sclk;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      sclk <= 1'b0;
      mclk <= 1'b0;
    end else begin
      if (!range_q || cnt[0]) mclk <= ~mclk;
      if (at_end) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2: counter stays inside the selected half-period
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < half_len);

  // R2: bit clock only moves at the end of a half-period or on restart
  a_r2_sclk_moves_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(at_end || restart));

  // R9: restart brings both clocks low
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !sclk && !mclk));

endmodule

// File: rtl/i2s_tx_serial.sv
module i2s_tx_serial #(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            fall,
  input  logic            port_on,
  input  logic            s_valid,
  input  logic [WORD-1:0] s_left,
  input  logic [WORD-1:0] s_right,
  output logic            s_ready,
  output logic            lr,
  output logic            sdata
);

  localparam int FRAME  = 2 * WORD;
  localparam int SLOT_W = $clog2(FRAME);

  logic [SLOT_W-1:0] slot;
  logic [FRAME-1:0]  shreg;
  logic [WORD-1:0]   hold_l;
  logic [WORD-1:0]   hold_r;
  logic [FRAME-1:0]  next_pair;
  logic              last_slot;
  logic              take;

  assign last_slot = (slot == SLOT_W'(FRAME - 1));
  assign s_ready   = port_on && fall && last_slot;
  assign take      = s_ready && s_valid;
  assign next_pair = take ? {s_left, s_right} : {hold_l, hold_r};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (take) begin
      hold_l <= s_left;
      hold_r <= s_right;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot  <= '0;
      lr    <= 1'b0;
      sdata <= 1'b0;
      shreg <= '0;
    end else if (restart) begin
      slot  <= '0;
      lr    <= 1'b0;
      sdata <= 1'b0;
      shreg <= next_pair;
    end else if (fall) begin
      sdata <= shreg[FRAME-1];
      if (last_slot) begin
        slot  <= '0;
        lr    <= 1'b0;
        shreg <= next_pair;
      end else begin
        slot  <= slot + SLOT_W'(1);
        lr    <= (slot >= SLOT_W'(WORD - 1));
        shreg <= shreg << 1;
      end
    end
  end

  // R8: held pair only changes through the handshake
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(hold_l) && $stable(hold_r)));

  // R6: word select returns to left at every frame wrap
  a_r6_left_after_wrap: assert property (@(posedge clk) disable iff (rst)
    (fall && last_slot && !restart) |=> !lr);

  // R6: word select only moves on a bit-clock falling edge or restart
  a_r6_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(lr) |-> $past(fall || restart));

  // R7: data only moves on a bit-clock falling edge or restart
  a_r7_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $past(fall || restart));

endmodule

// File: rtl/i2s_tx_port.sv
module i2s_tx_port
  import i2s_tx_pkg::*;
#(
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_range_hi,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_wdata,
  output logic [3:0]      cfg_rdata,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [WORD-1:0] s_left,
  input  logic [WORD-1:0] s_right,
  input  logic [3:0]      gpio_out,
  input  logic [3:0]      gpio_oe,
  output logic [3:0]      pin_out,
  output logic [3:0]      pin_oe
);

  cfg_t             cfg_q;
  logic             range_q;
  logic             restart;
  logic [CNT_W-1:0] half_len;
  logic             mclk;
  logic             sclk;
  logic             fall;
  logic             lr;
  logic             sdata;
  logic [NPIN-1:0]  func_out;

  i2s_tx_cfg i_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_data  (cfg_wdata),
    .range_hi (clk_range_hi),
    .cfg_q    (cfg_q),
    .range_q  (range_q),
    .restart  (restart)
  );

  assign half_len  = half_period(cfg_q.rate, range_q);
  assign cfg_rdata = cfg_q;

  i2s_tx_clkgen #(.CW(CNT_W)) i_clkgen (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .half_len (half_len),
    .range_q  (range_q),
    .mclk     (mclk),
    .sclk     (sclk),
    .fall     (fall)
  );

  i2s_tx_serial #(.WORD(WORD)) i_serial (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .fall    (fall),
    .port_on (cfg_q.port_on),
    .s_valid (s_valid),
    .s_left  (s_left),
    .s_right (s_right),
    .s_ready (s_ready),
    .lr      (lr),
    .sdata   (sdata)
  );

  always_comb begin
    func_out         = '0;
    func_out[PIN_MC] = mclk & cfg_q.mclk_on;
    func_out[PIN_BC] = sclk;
    func_out[PIN_WS] = lr;
    func_out[PIN_SD] = sdata;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[p] <= 1'b0;
        pin_oe[p]  <= 1'b0;
      end else if (cfg_q.port_on) begin
        pin_out[p] <= func_out[p];
        pin_oe[p]  <= 1'b1;
      end else begin
        pin_out[p] <= gpio_out[p];
        pin_oe[p]  <= gpio_oe[p];
      end
    end
  end

  // R4: disabled port passes the GPIO controls through
  a_r4_gpio_pass: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.port_on |=> (pin_out == $past(gpio_out) && pin_oe == $past(gpio_oe)));

  // R5: enabled port drives every pin
  a_r5_all_driven: assert property (@(posedge clk) disable iff (rst)
    cfg_q.port_on |=> (&pin_oe));

  // R3: gated master clock pin stays low
  a_r3_mclk_gated: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.port_on && !cfg_q.mclk_on) |=> !pin_out[PIN_MC]);

endmodule

// File: tb/test_i2s_tx_port.sv
module test_i2s_tx_port;

  localparam int WORD  = 16;
  localparam int FRAME = 2 * WORD;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            clk_range_hi = 1'b0;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_wdata = '0;
  logic [3:0]      cfg_rdata;
  logic            s_valid = 1'b0;
  logic            s_ready;
  logic [WORD-1:0] s_left = '0;
  logic [WORD-1:0] s_right = '0;
  logic [3:0]      gpio_out = 4'h5;
  logic [3:0]      gpio_oe = 4'hA;
  logic [3:0]      pin_out;
  logic [3:0]      pin_oe;

  always #5 clk = ~clk;

  i2s_tx_port #(.WORD(WORD)) i_i2s_tx_port (
    .clk(clk), .rst(rst), .clk_range_hi(clk_range_hi),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // sample pair source
  typedef struct { logic [WORD-1:0] l; logic [WORD-1:0] r; } pair_t;
  pair_t q[$];
  bit    feed_on = 1'b1;

  always @(negedge clk) begin
    while (q.size() < 4) begin
      pair_t p;
      p.l = WORD'($urandom);
      p.r = WORD'($urandom);
      q.push_back(p);
    end
    s_valid = feed_on;
    s_left  = q[0].l;
    s_right = q[0].r;
  end

  // behavioural reference model
  logic [3:0]      m_cfg;
  bit              m_range, m_sclk, m_mclk, m_lr, m_sd, m_func;
  int              m_cnt, m_slot;
  logic [WORD-1:0] m_hl, m_hr;
  logic [3:0]      m_pin, m_oe;

  function automatic int m_half();
    int b;
    case (m_cfg[1:0])
      2'b01:   b = 4;
      2'b10:   b = 2;
      default: b = 8;
    endcase
    return m_range ? 2 * b : b;
  endfunction

  function automatic bit m_ready();
    return m_cfg[2] && m_sclk && (m_cnt == m_half() - 1) && (m_slot == FRAME - 1);
  endfunction

  always @(posedge clk) begin
    int h;
    bit acc, rs;
    logic [WORD-1:0] nl, nr;
    if (rst) begin
      m_cfg = '0; m_range = 0; m_sclk = 0; m_mclk = 0; m_lr = 0; m_sd = 0;
      m_cnt = 0; m_slot = 0; m_hl = '0; m_hr = '0; m_pin = '0; m_oe = '0; m_func = 0;
    end else begin
      h   = m_half();
      acc = m_ready() && s_valid;
      nl  = acc ? s_left  : m_hl;
      nr  = acc ? s_right : m_hr;
      rs  = (cfg_we && cfg_wdata[2:0] != m_cfg[2:0]) || (clk_range_hi != m_range) || !m_cfg[2];
      m_func = m_cfg[2];
      m_pin  = m_cfg[2] ? {m_sd, m_lr, m_sclk, m_mclk & m_cfg[3]} : gpio_out;
      m_oe   = m_cfg[2] ? 4'hF : gpio_oe;
      if (rs) begin
        m_cnt = 0; m_sclk = 0; m_mclk = 0; m_slot = 0; m_lr = 0; m_sd = 0;
      end else begin
        if (!m_range || (m_cnt % 2 == 1)) m_mclk = ~m_mclk;
        if (m_cnt == h - 1) begin
          m_cnt = 0;
          if (m_sclk) begin
            m_slot = (m_slot + 1) % FRAME;
            m_lr   = (m_slot >= WORD);
            if (m_slot == 0)         m_sd = m_hr[0];
            else if (m_slot <= WORD) m_sd = m_hl[WORD - m_slot];
            else                     m_sd = m_hr[FRAME - m_slot];
          end
          m_sclk = ~m_sclk;
        end else begin
          m_cnt++;
        end
      end
      if (acc) void'(q.pop_front());
      m_hl = nl;
      m_hr = nr;
      if (cfg_we) m_cfg = cfg_wdata;
      m_range = clk_range_hi;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      chk("R1 cfg readback", cfg_rdata, m_cfg);
      chk("R8 ready", s_ready, m_ready());
      if (!m_func) begin
        chk("R4 gpio value", pin_out, m_pin);
        chk("R4 gpio enable", pin_oe, m_oe);
      end else begin
        chk("R5 enables", pin_oe, m_oe);
        chk("R3 master clock", pin_out[0], m_pin[0]);
        chk("R2 bit clock", pin_out[1], m_pin[1]);
        chk("R6 word select", pin_out[2], m_pin[2]);
        chk("R7 data", pin_out[3], m_pin[3]);
      end
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd >= 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, 150000);
      report();
      $finish;
    end
  end

  task automatic wcfg(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(input int idx, output int per);
    int  c = 0;
    bit  p, started = 0;
    p = pin_out[idx];
    forever begin
      @(negedge clk);
      if (started) c++;
      if (!p && pin_out[idx]) begin
        if (started) break;
        started = 1; c = 0;
      end
      p = pin_out[idx];
    end
    per = c;
  endtask

  task automatic wait_rise();
    bit p;
    p = pin_out[1];
    forever begin
      @(negedge clk);
      if (!p && pin_out[1]) break;
      p = pin_out[1];
    end
  endtask

  initial begin
    int per;
    int gap;
    logic [WORD-1:0] exp_l, got;
    repeat (4) @(negedge clk);
    chk("R1 reset value", cfg_rdata, 4'h0);
    chk("R4 pins idle in reset", pin_oe, 4'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 gpio after reset", pin_out, 4'h5);
    chk("R4 gpio enable after reset", pin_oe, 4'hA);
    gpio_out = 4'h3; gpio_oe = 4'h6;
    repeat (2) @(negedge clk);
    chk("R4 gpio follows", {pin_oe, pin_out}, 8'h63);

    wcfg(4'hC);
    measure(1, per); chk("R2 rate 00 period", per, 16);
    measure(0, per); chk("R3 master clock period", per, 2);
    repeat (600) @(negedge clk);
    wcfg(4'hD); measure(1, per); chk("R2 rate 01 period", per, 8);
    repeat (300) @(negedge clk);
    wcfg(4'hE); measure(1, per); chk("R2 rate 10 period", per, 4);
    repeat (300) @(negedge clk);
    wcfg(4'hF); measure(1, per); chk("R2 reserved rate period", per, 16);

    clk_range_hi = 1'b1;
    measure(1, per); chk("R2 high range period", per, 32);
    measure(0, per); chk("R3 high range master clock", per, 4);
    repeat (1100) @(negedge clk);
    wcfg(4'h7);
    repeat (100) @(negedge clk);
    chk("R3 gated master clock", pin_out[0], 1'b0);
    measure(1, per); chk("R3 bit clock runs while gated", per, 32);
    clk_range_hi = 1'b0;

    feed_on = 1'b0;
    repeat (1200) @(negedge clk);
    feed_on = 1'b1;

    wcfg(4'h4);
    @(negedge clk);
    chk("R9 restart clock low", pin_out[1], 1'b0);
    chk("R9 restart word select low", pin_out[2], 1'b0);

    // R9: flipping only the master clock gate keeps the bit-clock cadence
    wait_rise();
    gap = 0;
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 4'hC; gap++;
    @(negedge clk); cfg_we = 1'b0; gap++;
    wait_rise();
    chk("R9 no restart on gate write", pin_out[1], 1'b1);
    measure(1, per); chk("R9 cadence kept", per, 16);

    // R10: accept a pair in the same cycle as a restarting write
    repeat (3) @(negedge clk);
    while (!s_ready) @(negedge clk);
    exp_l = s_left;
    chk("R10 pair offered", s_valid, 1'b1);
    cfg_we = 1'b1; cfg_wdata = 4'hD;
    @(negedge clk);
    cfg_we = 1'b0;
    begin
      int  rises = 0;
      bit  p;
      got = '0;
      p = pin_out[1];
      while (rises < 17) begin
        @(negedge clk);
        if (!p && pin_out[1]) begin
          rises++;
          if (rises >= 2) got = {got[WORD-2:0], pin_out[3]};
        end
        p = pin_out[1];
      end
    end
    chk("R10 first left word", got, exp_l);
    repeat (400) @(negedge clk);

    wcfg(4'h0);
    repeat (20) @(negedge clk);
    chk("R4 back to gpio", {pin_oe, pin_out}, {gpio_oe, gpio_out});

    report();
    $finish;
  end

endmodule